// File: doc/BRIEF.md
# USB PHY Power-Up Sequencer

This block sits on the controller side of a USB 2.0 PHY and takes the PHY from its held-in-reset, powered-down condition to normal operation after software issues a single start pulse. It walks a fixed chain of steps, one state per step: take the PHY out of reset, enable routing of the port pins, apply the chosen clock source and frequency code, set the power and detector controls, and finally switch on the PHY PLL.

After the PLL is switched on, the sequencer waits for the PHY to report a good clock. That status crosses into the controller clock domain through a two-stage synchronizer. When it arrives, the sequencer raises `done`. If it does not arrive within a programmable number of cycles, the sequencer raises `timeout` and returns to idle with the PLL still on, so that software can decide what to do next. While a sequence is running, `busy` is high and further start pulses have no effect.

Top module: `usbphy_pwrup_seq`

## Requirements
- R1: While reset is asserted, the outputs take these values: `phy_rst_o`=1, `phy_pwrdn_o`=1, `otg_pwrdn_o`=1, and every other control output, `clk_freq_sel_o`, `done_o`, `busy_o` and `timeout_o` are 0.
- R2: A start pulse that is sampled high at clock edge E0 while the block is idle takes effect at E0 itself. After E0, `busy_o`=1, `phy_rst_o`=0, and all other configuration outputs have their R1 defaults.
- R3: At edge E0+1, `route_en_o` goes to 1. At E0+2, `clk_ext_sel_o` (1 = external source) and `clk_freq_sel_o` take the values that were present on `clk_ext_i` and `clk_freq_i` at E0. Neither changes earlier.
- R4: At E0+3, `phy_pwrdn_o` and `otg_pwrdn_o` go to 0, and `data_pol_o`, `sess_end_en_o` and `vbus_cmp_en_o` go to 1. The PLL is still off at that point.
- R5: `pll_en_o` goes to 1 at E0+4. This is the last configuration change, and it happens only after every earlier step has been applied.
- R6: The clock-good input passes through two flip-flops before it is used. If it goes high before edge A, with A at or after E0+5, then `done_o` goes to 1 and `busy_o` to 0 at edge A+2 and not before. `done_o` never rises without a good clock.
- R7: The wait for clock-good starts at E0+5 and lasts `tmo_limit_i`+1 edges. If clock-good never arrives, `timeout_o` goes to 1 and `busy_o` to 0 at edge E0+6+`tmo_limit_i`, while `pll_en_o` stays at 1 and `done_o` stays at 0.
- R8: A start pulse that arrives while `busy_o`=1 is ignored. The step sequence, its timing and the captured clock settings are unaffected.
- R9: `done_o` and `timeout_o` keep their values until the next accepted start. That start clears both flags and returns the configuration outputs to their R1 defaults, except for the PHY reset, which is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Start pulse; accepted only while idle |
| clk_ext_i | input | 1 | Requested PHY clock source, 1 = external |
| clk_freq_i | input | FREQ_W | Requested PHY reference-frequency code |
| tmo_limit_i | input | TMO_W | Maximum wait for clock-good, in cycles |
| phy_clk_good_i | input | 1 | PHY clock-good status (asynchronous) |
| phy_rst_o | output | 1 | PHY reset, 1 = held in reset |
| route_en_o | output | 1 | Port-pin routing enable |
| clk_ext_sel_o | output | 1 | Applied PHY clock source |
| clk_freq_sel_o | output | FREQ_W | Applied PHY frequency code |
| phy_pwrdn_o | output | 1 | PHY power-down, 1 = powered down |
| otg_pwrdn_o | output | 1 | OTG-block power-down, 1 = powered down |
| data_pol_o | output | 1 | Data-polarity control |
| sess_end_en_o | output | 1 | Session-end detector enable |
| vbus_cmp_en_o | output | 1 | VBUS comparator enable |
| pll_en_o | output | 1 | PHY PLL enable |
| done_o | output | 1 | Sequence completed with a good clock |
| busy_o | output | 1 | Sequence in progress |
| timeout_o | output | 1 | Wait for clock-good expired |

## Verification
The timer assertion assumes that `tmo_limit_i` holds steady for the whole of a wait. The bench meets this by changing the limit only while the block is idle. The assertions also assume that `clk_ext_i` and `clk_freq_i` matter only at the edge where a start is accepted. The bench deliberately changes them alongside an ignored start to show that the captured values are kept. Clock-good is changed only on falling edges, and it stays high until the sequence completes, so the two-stage delay is deterministic and `done_o` can be checked at an exact edge.

// File: rtl/usbphy_seq_pkg.sv
package usbphy_seq_pkg;

  // Step states in the order they are visited; the order itself is behaviour.
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_REL   = 3'd1,
    ST_ROUTE = 3'd2,
    ST_CLK   = 3'd3,
    ST_CFG   = 3'd4,
    ST_PLL   = 3'd5,
    ST_WAIT  = 3'd6
  } seq_st_e;

endpackage

// File: rtl/usbphy_sync.sv
module usbphy_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end

      // R6: the last stage carries the previous cycle's value of the stage before it
      a_r6_sync_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> (chain_q[STAGES-1] == $past(chain_q[STAGES-2])));
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/usbphy_wait_timer.sv
module usbphy_wait_timer #(
  parameter int unsigned TMO_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             expired_o
);

  logic [TMO_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign expired_o = run_i && (cnt_q == limit_i);
  assign cnt_en    = clr_i || (run_i && !expired_o);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)       cnt_d = '0;
    else if (run_i)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R7: with a steady limit the count never passes it while waiting
  a_r7_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q <= limit_i));

endmodule

// File: rtl/usbphy_seq_fsm.sv
module usbphy_seq_fsm
  import usbphy_seq_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    start_i,
  input  logic    good_i,
  input  logic    expired_i,
  output logic    ld_o,
  output seq_st_e ld_state_o,
  output logic    waiting_o,
  output logic    busy_o,
  output logic    done_o,
  output logic    timeout_o
);

  seq_st_e state_q, state_d;
  logic    done_q, done_d, tmo_q, tmo_d;
  logic    accept, flag_en;

  assign accept = (state_q == ST_IDLE) && start_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_REL;
      ST_REL:   state_d = ST_ROUTE;
      ST_ROUTE: state_d = ST_CLK;
      ST_CLK:   state_d = ST_CFG;
      ST_CFG:   state_d = ST_PLL;
      ST_PLL:   state_d = ST_WAIT;
      ST_WAIT:  if (good_i || expired_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    done_d  = done_q;
    tmo_d   = tmo_q;
    flag_en = 1'b0;
    if (accept) begin
      done_d  = 1'b0;
      tmo_d   = 1'b0;
      flag_en = 1'b1;
    end else if (state_q == ST_WAIT) begin
      if (good_i) begin
        done_d  = 1'b1;
        flag_en = 1'b1;
      end else if (expired_i) begin
        tmo_d   = 1'b1;
        flag_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      tmo_q  <= 1'b0;
    end else if (flag_en) begin
      done_q <= done_d;
      tmo_q  <= tmo_d;
    end
  end

  assign ld_o       = (state_d != state_q);
  assign ld_state_o = state_d;
  assign waiting_o  = (state_q == ST_WAIT);
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign timeout_o  = tmo_q;

  // R2: an accepted start enters reset release with both flags cleared
  a_r2_start_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_IDLE) && start_i) |=> ((state_q == ST_REL) && !done_q && !tmo_q));

  // R6: done only rises after a synchronized good clock was seen
  a_r6_done_needs_good: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(good_i));

  // R8: while busy, a start never restarts the chain
  a_r8_busy_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> (state_q != ST_REL));

  // R9: the two result flags never coexist
  a_r9_flags_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_q && tmo_q));

endmodule

// File: rtl/usbphy_ctl_regs.sv
module usbphy_ctl_regs
  import usbphy_seq_pkg::*;
#(
  parameter int unsigned FREQ_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  seq_st_e           ld_state_i,
  input  logic              clk_ext_i,
  input  logic [FREQ_W-1:0] clk_freq_i,
  output logic              phy_rst_o,
  output logic              route_en_o,
  output logic              clk_ext_sel_o,
  output logic [FREQ_W-1:0] clk_freq_sel_o,
  output logic              phy_pwrdn_o,
  output logic              otg_pwrdn_o,
  output logic              data_pol_o,
  output logic              sess_end_en_o,
  output logic              vbus_cmp_en_o,
  output logic              pll_en_o
);

  logic              cap_ext_q;
  logic [FREQ_W-1:0] cap_freq_q;
  logic              cap_en;

  assign cap_en = ld_i && (ld_state_i == ST_REL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_ext_q  <= 1'b0;
      cap_freq_q <= '0;
    end else if (cap_en) begin
      cap_ext_q  <= clk_ext_i;
      cap_freq_q <= clk_freq_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phy_rst_o      <= 1'b1;
      route_en_o     <= 1'b0;
      clk_ext_sel_o  <= 1'b0;
      clk_freq_sel_o <= '0;
      phy_pwrdn_o    <= 1'b1;
      otg_pwrdn_o    <= 1'b1;
      data_pol_o     <= 1'b0;
      sess_end_en_o  <= 1'b0;
      vbus_cmp_en_o  <= 1'b0;
      pll_en_o       <= 1'b0;
    end else if (ld_i) begin
      unique case (ld_state_i)
        ST_REL: begin
          phy_rst_o      <= 1'b0;
          route_en_o     <= 1'b0;
          clk_ext_sel_o  <= 1'b0;
          clk_freq_sel_o <= '0;
          phy_pwrdn_o    <= 1'b1;
          otg_pwrdn_o    <= 1'b1;
          data_pol_o     <= 1'b0;
          sess_end_en_o  <= 1'b0;
          vbus_cmp_en_o  <= 1'b0;
          pll_en_o       <= 1'b0;
        end
        ST_ROUTE: route_en_o <= 1'b1;
        ST_CLK: begin
          clk_ext_sel_o  <= cap_ext_q;
          clk_freq_sel_o <= cap_freq_q;
        end
        ST_CFG: begin
          phy_pwrdn_o   <= 1'b0;
          otg_pwrdn_o   <= 1'b0;
          data_pol_o    <= 1'b1;
          sess_end_en_o <= 1'b1;
          vbus_cmp_en_o <= 1'b1;
        end
        ST_PLL:  pll_en_o <= 1'b1;
        default: ;
      endcase
    end
  end

  // R3: routing is never enabled while the PHY is held in reset
  a_r3_route_after_rel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(route_en_o) |-> !phy_rst_o);

  // R4: powering up the PHY comes after routing is enabled
  a_r4_cfg_after_route: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(phy_pwrdn_o) |-> (route_en_o && !phy_rst_o));

  // R5: the PLL turns on only once every earlier step holds
  a_r5_pll_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pll_en_o) |-> (!phy_rst_o && route_en_o && !phy_pwrdn_o && !otg_pwrdn_o
                         && data_pol_o && sess_end_en_o && vbus_cmp_en_o));

endmodule

// File: rtl/usbphy_pwrup_seq.sv
module usbphy_pwrup_seq
  import usbphy_seq_pkg::*;
#(
  parameter int unsigned FREQ_W      = 4,
  parameter int unsigned TMO_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              clk_ext_i,
  input  logic [FREQ_W-1:0] clk_freq_i,
  input  logic [TMO_W-1:0]  tmo_limit_i,
  input  logic              phy_clk_good_i,
  output logic              phy_rst_o,
  output logic              route_en_o,
  output logic              clk_ext_sel_o,
  output logic [FREQ_W-1:0] clk_freq_sel_o,
  output logic              phy_pwrdn_o,
  output logic              otg_pwrdn_o,
  output logic              data_pol_o,
  output logic              sess_end_en_o,
  output logic              vbus_cmp_en_o,
  output logic              pll_en_o,
  output logic              done_o,
  output logic              busy_o,
  output logic              timeout_o
);

  logic [1:0] rst_sync_q;
  logic       rst_n;
  logic       good_s;
  logic       expired;
  logic       ld;
  seq_st_e    ld_state;
  logic       waiting;
  logic       tmr_clr;

  // reset asserts at once, releases two edges later
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  usbphy_sync #(.STAGES(SYNC_STAGES)) u_good_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .d_i    (phy_clk_good_i),
    .q_o    (good_s)
  );

  usbphy_seq_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .start_i    (start_i),
    .good_i     (good_s),
    .expired_i  (expired),
    .ld_o       (ld),
    .ld_state_o (ld_state),
    .waiting_o  (waiting),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .timeout_o  (timeout_o)
  );

  assign tmr_clr = ld && (ld_state == ST_WAIT);

  usbphy_wait_timer #(.TMO_W(TMO_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .clr_i     (tmr_clr),
    .run_i     (waiting),
    .limit_i   (tmo_limit_i),
    .expired_o (expired)
  );

  usbphy_ctl_regs #(.FREQ_W(FREQ_W)) u_ctl (
    .clk_i          (clk_i),
    .rst_ni         (rst_n),
    .ld_i           (ld),
    .ld_state_i     (ld_state),
    .clk_ext_i      (clk_ext_i),
    .clk_freq_i     (clk_freq_i),
    .phy_rst_o      (phy_rst_o),
    .route_en_o     (route_en_o),
    .clk_ext_sel_o  (clk_ext_sel_o),
    .clk_freq_sel_o (clk_freq_sel_o),
    .phy_pwrdn_o    (phy_pwrdn_o),
    .otg_pwrdn_o    (otg_pwrdn_o),
    .data_pol_o     (data_pol_o),
    .sess_end_en_o  (sess_end_en_o),
    .vbus_cmp_en_o  (vbus_cmp_en_o),
    .pll_en_o       (pll_en_o)
  );

  // R7: leaving the wait by expiry keeps the PLL running
  a_r7_pll_kept: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(timeout_o) |-> (pll_en_o && !busy_o));

endmodule

// File: tb/usbphy_pwrup_seq_bench.sv
module usbphy_pwrup_seq_bench;

  localparam int FREQ_W = 4;
  localparam int TMO_W  = 16;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start;
  logic              ext;
  logic [FREQ_W-1:0] freq;
  logic [TMO_W-1:0]  lim;
  logic              good;
  logic              phy_rst, route, ext_sel, pwrdn, otg, pol, sess, vbus, pll;
  logic              done, busy, tmo;
  logic [FREQ_W-1:0] freq_sel;

  int checks = 0;
  int errors = 0;
  bit reported = 0;

  always #5 clk = ~clk;

  usbphy_pwrup_seq #(.FREQ_W(FREQ_W), .TMO_W(TMO_W)) u_usbphy_pwrup_seq (
    .clk_i (clk), .rst_ni (rst_n), .start_i (start), .clk_ext_i (ext),
    .clk_freq_i (freq), .tmo_limit_i (lim), .phy_clk_good_i (good),
    .phy_rst_o (phy_rst), .route_en_o (route), .clk_ext_sel_o (ext_sel),
    .clk_freq_sel_o (freq_sel), .phy_pwrdn_o (pwrdn), .otg_pwrdn_o (otg),
    .data_pol_o (pol), .sess_end_en_o (sess), .vbus_cmp_en_o (vbus),
    .pll_en_o (pll), .done_o (done), .busy_o (busy), .timeout_o (tmo)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
    end
  endtask

  // one start pulse; returns at the falling edge just after E0
  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; ext = 1'b0; freq = '0; lim = 16'd20; good = 1'b0;
    repeat (3) step();
    chk("R1", "phy_rst", phy_rst, 1);
    chk("R1", "pwrdn/otg", {pwrdn, otg}, 2'b11);
    chk("R1", "pol/sess/vbus/pll/route/ext", {pol, sess, vbus, pll, route, ext_sel}, 0);
    chk("R1", "freq_sel", freq_sel, 0);
    chk("R1", "done/busy/tmo", {done, busy, tmo}, 0);
    rst_n = 1'b1;
    repeat (4) step();
    chk("R1", "idle after release", {busy, phy_rst}, 2'b01);
  endtask

  task automatic t_full_sequence();
    ext = 1'b1; freq = 4'hA; lim = 16'd50; good = 1'b0;
    pulse_start();                                   // after E0
    ext = 1'b0; freq = 4'h3;                         // must not matter any more
    chk("R2", "busy", busy, 1);
    chk("R2", "phy_rst released", phy_rst, 0);
    chk("R2", "route still off", route, 0);
    step();                                          // E0+1
    chk("R3", "route on", route, 1);
    chk("R3", "clock not yet applied", {ext_sel, freq_sel}, 0);
    step();                                          // E0+2
    chk("R3", "clock source", ext_sel, 1);
    chk("R3", "clock freq", freq_sel, 4'hA);
    chk("R4", "power still down", {pwrdn, otg}, 2'b11);
    step();                                          // E0+3
    chk("R4", "power up", {pwrdn, otg}, 2'b00);
    chk("R4", "pol/sess/vbus", {pol, sess, vbus}, 3'b111);
    chk("R5", "pll not yet", pll, 0);
    step();                                          // E0+4
    chk("R5", "pll on", pll, 1);
    step();                                          // E0+5, now waiting
    chk("R6", "no done before good", done, 0);
    good = 1'b1;                                     // before edge A = E0+6
    step();
    chk("R6", "done at A", done, 0);
    step();
    chk("R6", "done at A+1", {done, busy}, 2'b01);
    step();
    chk("R6", "done at A+2", {done, busy}, 2'b10);
    repeat (3) step();
    chk("R9", "done held", {done, tmo}, 2'b10);
  endtask

  task automatic t_restart_after_done();
    good = 1'b0;
    pulse_start();
    chk("R9", "done cleared", done, 0);
    chk("R9", "config back to default", {pll, route, pwrdn, otg, pol}, 5'b00110);
    chk("R9", "still released", {phy_rst, busy}, 2'b01);
    repeat (6) step();
    good = 1'b1;
    repeat (4) step();
    chk("R9", "second run done", {done, busy}, 2'b10);
  endtask

  task automatic t_timeout();
    good = 1'b0; lim = 16'd6;
    pulse_start();                                   // after E0
    repeat (5) step();                               // E0+5
    repeat (6) step();                               // E0+5+lim
    chk("R7", "not yet expired", {tmo, busy}, 2'b01);
    step();                                          // E0+6+lim
    chk("R7", "timeout raised", {tmo, busy, done}, 3'b100);
    chk("R7", "pll kept on", pll, 1);
    repeat (4) step();
    chk("R9", "timeout held", tmo, 1);
    pulse_start();
    chk("R9", "timeout cleared by start", {tmo, busy}, 2'b01);
    good = 1'b1;
    repeat (10) step();
    chk("R9", "recovered run done", {done, tmo, busy}, 3'b100);
  endtask

  task automatic t_busy_ignore();
    good = 1'b1; ext = 1'b0; freq = 4'h3; lim = 16'd20;
    pulse_start();                                   // after E0
    step();                                          // after E0+1
    start = 1'b1; ext = 1'b1; freq = 4'h5;           // sampled at E0+2
    step();
    start = 1'b0;
    chk("R8", "captured freq kept", freq_sel, 4'h3);
    chk("R8", "captured source kept", ext_sel, 0);
    chk("R8", "no restart", {phy_rst, route, busy}, 3'b011);
    step();                                          // E0+3
    chk("R8", "sequence continues", pwrdn, 0);
    step();                                          // E0+4
    step();                                          // E0+5
    chk("R8", "still waiting", {done, busy}, 2'b01);
    step();                                          // E0+6, good already synced
    chk("R8", "completes on time", {done, busy}, 2'b10);
  endtask

  initial begin
    t_reset();
    t_full_sequence();
    t_restart_after_done();
    t_timeout();
    t_busy_ignore();
    repeat (3) step();
    report();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    report();
    $finish;
  end

endmodule